// File: doc/BRIEF.md
# Operand-Selecting Execute ALU

This block is the arithmetic and logic unit of the execute stage in a small RISC pipeline. Decode hands it small select fields. These fields pick operand A, operand B and the carry-in from a fixed set of sources: the two register values, the extended immediate, the program counter, the status register and a few constants. A function code then picks the operation. The block registers the result and a carry flag, and that registered flag can also be fed back as the carry-in of a later operation.

Subtraction, compare and AND-NOT have no operation codes of their own. Decode builds them from the input multiplexers. It inverts register A, or inverts operand B, and then picks the carry-in. For example, "inverted A plus B plus one" yields B minus A. Compare uses the same sum, and the top bit of the result is then replaced by a greater-than flag, evaluated either signed or unsigned. One-bit right shifts and sign extensions complete the set.

Top module: `opsel_alu`

## Requirements
- R1: `a_sel` chooses operand A as follows: 0 selects `reg_a`, 1 selects bitwise `~reg_a`, 2 selects `pc`, 3 selects zero, and 4 selects `status` zero-extended to the data width. The values 5 to 7 select zero.
- R2: `b_sel` chooses operand B as follows: 0 selects `reg_b`, 1 selects `imm`, 2 selects `~reg_b`, and 3 selects `~imm`.
- R3: `cin_sel` chooses the carry-in as follows: 0 gives zero, 1 gives one, and 2 gives the registered `carry` flag. The value 3 gives zero.
- R4: Function 0 (add) produces opA + opB + cin. Its carry out is bit 32 of the 33-bit sum.
- R5: With `a_sel`=1 and `cin_sel`=1, function 0 yields `reg_b - reg_a`, and its carry out is 1 when no borrow occurs.
- R6: Function 1 is OR, function 2 is AND and function 3 is XOR. AND with `b_sel`=2 or `b_sel`=3 performs AND-NOT.
- R7: Function 4 (signed compare) and function 5 (unsigned compare) produce opA + opB + cin. Bit 31 of the result is replaced by the flag "X > opB", where X = ~opA (that is, `reg_a` when `a_sel`=1). Function 4 evaluates the flag as signed and function 5 as unsigned. The carry out is the sum's bit 32.
- R8: Function 6 is an arithmetic right shift of opA by one bit. Function 7 is a logical right shift. Function 8 shifts right through the carry, so that cin enters at bit 31. All three set their carry out to opA bit 0.
- R9: Function 9 sign-extends opA[7:0] and function 10 sign-extends opA[15:0]. Function codes 11 to 15 produce zero.
- R10: `carry` is written only when `carry_we` is 1 and the function is one of 0, 4, 5, 6, 7 or 8. Otherwise `carry` keeps its value.
- R11: `result` and `carry` update on the rising edge one cycle after the inputs are applied. While `stall` is 1, both hold their values whatever the other inputs are.
- R12: A synchronous `rst` clears `result` and `carry` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the output registers |
| reg_a | input | 32 | Register A value |
| reg_b | input | 32 | Register B value |
| imm | input | 32 | Extended immediate |
| pc | input | 32 | Program counter of the instruction |
| status | input | 32 | Machine status register |
| a_sel | input | 3 | Operand A source |
| b_sel | input | 2 | Operand B source |
| cin_sel | input | 2 | Carry-in source |
| fn_sel | input | 4 | Function code |
| carry_we | input | 1 | Carry flag update enable |
| result | output | 32 | Registered result |
| carry | output | 1 | Registered carry flag |

## Verification
Two things can collide in one cycle: reading the stored carry as the carry-in, and writing that same carry flag. This happens when a shift-through-carry or an add with carry runs with `carry_we` set. The vector table provokes it by chaining such operations, so each vector depends on the flag left by the one before. The expected values are worked out by hand from the previous step.

A second collision is between a stall and a pending carry write or new function. The directed test raises `stall` while `carry_we` is set with new operands. It then checks that both `result` and `carry` stay frozen, and that the next unstalled operation uses the flag as it stood before the stall.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;
   typedef enum logic [2:0] {
      ASRC_REG  = 3'd0,
      ASRC_NREG = 3'd1,
      ASRC_PC   = 3'd2,
      ASRC_ZERO = 3'd3,
      ASRC_STAT = 3'd4
   } asrc_e;

   typedef enum logic [1:0] {
      BSRC_REG  = 2'd0,
      BSRC_IMM  = 2'd1,
      BSRC_NREG = 2'd2,
      BSRC_NIMM = 2'd3
   } bsrc_e;

   typedef enum logic [1:0] {
      CSRC_ZERO = 2'd0,
      CSRC_ONE  = 2'd1,
      CSRC_FLAG = 2'd2
   } csrc_e;

   typedef enum logic [3:0] {
      FN_ADD   = 4'd0,
      FN_OR    = 4'd1,
      FN_AND   = 4'd2,
      FN_XOR   = 4'd3,
      FN_CMPS  = 4'd4,
      FN_CMPU  = 4'd5,
      FN_SRA   = 4'd6,
      FN_SRL   = 4'd7,
      FN_SRC   = 4'd8,
      FN_SEXB  = 4'd9,
      FN_SEXH  = 4'd10
   } fn_e;
endpackage

// File: rtl/opsel_alu_operands.sv
module opsel_alu_operands #(
   parameter int WIDTH    = 32,
   parameter int STATUS_W = 32
) (
   input  logic [WIDTH-1:0]    reg_a,
   input  logic [WIDTH-1:0]    reg_b,
   input  logic [WIDTH-1:0]    imm,
   input  logic [WIDTH-1:0]    pc,
   input  logic [STATUS_W-1:0] status,
   input  logic [2:0]          a_sel,
   input  logic [1:0]          b_sel,
   input  logic [1:0]          cin_sel,
   input  logic                flag,
   output logic [WIDTH-1:0]    op_a,
   output logic [WIDTH-1:0]    op_b,
   output logic                cin
);
   import opsel_alu_pkg::*;

   logic [WIDTH-1:0] status_ext;

   generate
      if (STATUS_W < WIDTH) begin : g_stat_pad
         assign status_ext = {{(WIDTH-STATUS_W){1'b0}}, status};
      end else begin : g_stat_cut
         assign status_ext = status[WIDTH-1:0];
      end
   endgenerate

   always_comb begin
      case (a_sel)
         ASRC_REG:  op_a = reg_a;
         ASRC_NREG: op_a = ~reg_a;
         ASRC_PC:   op_a = pc;
         ASRC_STAT: op_a = status_ext;
         default:   op_a = '0;
      endcase
   end

   always_comb begin
      case (b_sel)
         BSRC_REG:  op_b = reg_b;
         BSRC_IMM:  op_b = imm;
         BSRC_NREG: op_b = ~reg_b;
         default:   op_b = ~imm;
      endcase
   end

   always_comb begin
      case (cin_sel)
         CSRC_ONE:  cin = 1'b1;
         CSRC_FLAG: cin = flag;
         default:   cin = 1'b0;
      endcase
   end
endmodule

// File: rtl/opsel_alu_func.sv
module opsel_alu_func #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             cin,
   input  logic [3:0]       fn_sel,
   output logic [WIDTH-1:0] res,
   output logic             cout,
   output logic             cout_valid
);
   import opsel_alu_pkg::*;

   localparam int MSB = WIDTH - 1;

   logic [WIDTH:0]   sum;
   logic [WIDTH-1:0] a_true;
   logic             gt_s;
   logic             gt_u;

   assign sum    = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin};
   assign a_true = ~op_a;
   assign gt_s   = $signed(a_true) > $signed(op_b);
   assign gt_u   = a_true > op_b;

   always_comb begin
      res        = '0;
      cout       = 1'b0;
      cout_valid = 1'b0;
      case (fn_sel)
         FN_ADD: begin
            res = sum[MSB:0];
            cout = sum[WIDTH];
            cout_valid = 1'b1;
         end
         FN_OR:  res = op_a | op_b;
         FN_AND: res = op_a & op_b;
         FN_XOR: res = op_a ^ op_b;
         FN_CMPS: begin
            res = {gt_s, sum[MSB-1:0]};
            cout = sum[WIDTH];
            cout_valid = 1'b1;
         end
         FN_CMPU: begin
            res = {gt_u, sum[MSB-1:0]};
            cout = sum[WIDTH];
            cout_valid = 1'b1;
         end
         FN_SRA: begin
            res = {op_a[MSB], op_a[MSB:1]};
            cout = op_a[0];
            cout_valid = 1'b1;
         end
         FN_SRL: begin
            res = {1'b0, op_a[MSB:1]};
            cout = op_a[0];
            cout_valid = 1'b1;
         end
         FN_SRC: begin
            res = {cin, op_a[MSB:1]};
            cout = op_a[0];
            cout_valid = 1'b1;
         end
         FN_SEXB: res = {{(WIDTH-8){op_a[7]}}, op_a[7:0]};
         FN_SEXH: res = {{(WIDTH-16){op_a[15]}}, op_a[15:0]};
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu #(
   parameter int WIDTH    = 32,
   parameter int STATUS_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stall,
   input  logic [WIDTH-1:0] reg_a,
   input  logic [WIDTH-1:0] reg_b,
   input  logic [WIDTH-1:0] imm,
   input  logic [WIDTH-1:0] pc,
   input  logic [STATUS_W-1:0] status,
   input  logic [2:0]       a_sel,
   input  logic [1:0]       b_sel,
   input  logic [1:0]       cin_sel,
   input  logic [3:0]       fn_sel,
   input  logic             carry_we,
   output logic [WIDTH-1:0] result,
   output logic             carry
);
   import opsel_alu_pkg::*;

   generate
      if (WIDTH < 17) begin : g_bad_width
         $error("opsel_alu: WIDTH must be at least 17");
      end
      if (STATUS_W < 1) begin : g_bad_status
         $error("opsel_alu: STATUS_W must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] op_a, op_b, res_d;
   logic             cin, cout, cout_valid;

   opsel_alu_operands #(.WIDTH(WIDTH), .STATUS_W(STATUS_W)) u_ops (
      .reg_a(reg_a), .reg_b(reg_b), .imm(imm), .pc(pc), .status(status),
      .a_sel(a_sel), .b_sel(b_sel), .cin_sel(cin_sel), .flag(carry),
      .op_a(op_a), .op_b(op_b), .cin(cin)
   );

   opsel_alu_func #(.WIDTH(WIDTH)) u_fn (
      .op_a(op_a), .op_b(op_b), .cin(cin), .fn_sel(fn_sel),
      .res(res_d), .cout(cout), .cout_valid(cout_valid)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result <= '0;
         carry  <= 1'b0;
      end else if (!stall) begin
         result <= res_d;
         if (carry_we && cout_valid) carry <= cout;
      end
   end

   // Checks guarding the output registers
   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   always @(posedge clk) begin
      if (rst_q) begin
         assert_reset_clear_R12: assert (result == '0 && carry == 1'b0)
            else $error("result/carry not cleared after reset");
      end
   end

   assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
      stall |=> ($stable(result) && $stable(carry)));

   assert_carry_keep_R10: assert property (@(posedge clk) disable iff (rst)
      (!stall && !carry_we) |=> $stable(carry));

   assert_add_regs_R4: assert property (@(posedge clk) disable iff (rst)
      (!stall && fn_sel == 4'd0 && a_sel == 3'd0 && b_sel == 2'd0 && cin_sel == 2'd0)
      |=> result == $past(reg_a + reg_b));

   assert_shift_carry_R8: assert property (@(posedge clk) disable iff (rst)
      (!stall && carry_we && fn_sel == 4'd7 && a_sel == 3'd0)
      |=> carry == $past(reg_a[0]));
endmodule

// File: tb/opsel_alu_tb.sv
module opsel_alu_tb_top;
   logic        clk = 1'b0;
   logic        rst, stall, carry_we;
   logic [31:0] reg_a, reg_b, imm, pc, status;
   logic [2:0]  a_sel;
   logic [1:0]  b_sel, cin_sel;
   logic [3:0]  fn_sel;
   logic [31:0] result;
   logic        carry;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   opsel_alu dut_i (
      .clk(clk), .rst(rst), .stall(stall), .reg_a(reg_a), .reg_b(reg_b),
      .imm(imm), .pc(pc), .status(status), .a_sel(a_sel), .b_sel(b_sel),
      .cin_sel(cin_sel), .fn_sel(fn_sel), .carry_we(carry_we),
      .result(result), .carry(carry)
   );

   // asel, bsel, csel, fn, we, ra, rb, imm, expected result, expected carry
   localparam int NV = 18;
   localparam logic [140:0] VEC [0:NV-1] = '{
      {3'd0,2'd0,2'd0,4'd0, 1'b1,32'h5,32'h7,32'h0,32'hC,1'b0},
      {3'd0,2'd0,2'd0,4'd0, 1'b1,32'hFFFFFFFF,32'h1,32'h0,32'h0,1'b1},
      {3'd0,2'd0,2'd2,4'd0, 1'b0,32'h1,32'h1,32'h0,32'h3,1'b1},
      {3'd1,2'd0,2'd1,4'd0, 1'b1,32'h3,32'hA,32'h0,32'h7,1'b1},
      {3'd1,2'd0,2'd1,4'd0, 1'b1,32'hA,32'h3,32'h0,32'hFFFFFFF9,1'b0},
      {3'd1,2'd0,2'd1,4'd4, 1'b0,32'h1,32'hFFFFFFFF,32'h0,32'hFFFFFFFE,1'b0},
      {3'd1,2'd0,2'd1,4'd5, 1'b0,32'h1,32'hFFFFFFFF,32'h0,32'h7FFFFFFE,1'b0},
      {3'd0,2'd1,2'd0,4'd1, 1'b0,32'h0F00,32'h0,32'h00F0,32'h0FF0,1'b0},
      {3'd0,2'd2,2'd0,4'd2, 1'b0,32'hFF,32'h0F,32'h0,32'hF0,1'b0},
      {3'd3,2'd1,2'd0,4'd3, 1'b0,32'h0,32'h0,32'h1234,32'h1234,1'b0},
      {3'd2,2'd3,2'd0,4'd2, 1'b0,32'h0,32'h0,32'hF,32'h100,1'b0},
      {3'd4,2'd0,2'd0,4'd1, 1'b0,32'h0,32'h10,32'h0,32'h15,1'b0},
      {3'd0,2'd0,2'd0,4'd6, 1'b1,32'h80000001,32'h0,32'h0,32'hC0000000,1'b1},
      {3'd0,2'd0,2'd2,4'd8, 1'b1,32'h2,32'h0,32'h0,32'h80000001,1'b0},
      {3'd0,2'd0,2'd0,4'd7, 1'b1,32'h80000003,32'h0,32'h0,32'h40000001,1'b1},
      {3'd0,2'd0,2'd0,4'd9, 1'b1,32'h12345680,32'h0,32'h0,32'hFFFFFF80,1'b1},
      {3'd0,2'd0,2'd0,4'd10,1'b1,32'h00007FFF,32'h0,32'h0,32'h00007FFF,1'b1},
      {3'd0,2'd0,2'd0,4'd15,1'b1,32'h5,32'h0,32'h0,32'h0,1'b1}
   };

   task automatic check(input string req, input logic [31:0] act_r, input logic act_c,
                        input logic [31:0] exp_r, input logic exp_c);
      checks++;
      if (act_r !== exp_r || act_c !== exp_c) begin
         errors++;
         $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                  req, act_r, act_c, exp_r, exp_c);
      end
   endtask

   // Behavioural reference for the random phase
   function automatic logic [32:0] ref_model(input logic [2:0] as, input logic [1:0] bs,
         input logic [1:0] cs, input logic [3:0] f, input logic we,
         input logic [31:0] ra, input logic [31:0] rb, input logic [31:0] im,
         input logic fl);
      logic [31:0] a, b, r;
      logic c, nc;
      logic [32:0] s;
      a = (as == 0) ? ra : (as == 1) ? ~ra : (as == 2) ? pc : (as == 4) ? status : 32'h0;
      b = (bs == 0) ? rb : (bs == 1) ? im : (bs == 2) ? ~rb : ~im;
      c = (cs == 1) ? 1'b1 : (cs == 2) ? fl : 1'b0;
      s = a + b + c;
      nc = fl;
      r = 32'h0;
      if (f == 0) begin r = s[31:0]; if (we) nc = s[32]; end
      else if (f == 1) r = a | b;
      else if (f == 2) r = a & b;
      else if (f == 3) r = a ^ b;
      else if (f == 4 || f == 5) begin
         r = s[31:0];
         r[31] = (f == 4) ? ($signed(~a) > $signed(b)) : ((~a) > b);
         if (we) nc = s[32];
      end
      else if (f >= 6 && f <= 8) begin
         r = a >> 1;
         if (f == 6) r[31] = a[31];
         if (f == 8) r[31] = c;
         if (we) nc = a[0];
      end
      else if (f == 9)  r = {{24{a[7]}}, a[7:0]};
      else if (f == 10) r = {{16{a[15]}}, a[15:0]};
      return {nc, r};
   endfunction

   initial begin
      logic [32:0] m;
      logic mc;
      logic [31:0] hr;
      logic hc;
      rst = 1'b1; stall = 1'b0; carry_we = 1'b1;
      reg_a = 32'hFFFF; reg_b = 32'h1; imm = 32'h0;
      pc = 32'h100; status = 32'h5;
      a_sel = 3'd0; b_sel = 2'd0; cin_sel = 2'd0; fn_sel = 4'd0;
      repeat (3) @(negedge clk);
      check("R12 reset state", result, carry, 32'h0, 1'b0);
      rst = 1'b0;

      // R1..R10 via table walk; carry chains through consecutive vectors
      for (int i = 0; i < NV; i++) begin
         {a_sel, b_sel, cin_sel, fn_sel, carry_we, reg_a, reg_b, imm} = VEC[i][140:33];
         @(negedge clk);
         check($sformatf("R1-table/R4 R5 R6 R7 R8 R9 R10 R11 vec%0d", i),
               result, carry, VEC[i][32:1], VEC[i][0]);
      end

      // Random sweep against reference, with corner operands
      mc = carry;
      for (int i = 0; i < 300; i++) begin
         a_sel = 3'($urandom_range(0, 7));
         b_sel = 2'($urandom);
         cin_sel = 2'($urandom);
         fn_sel = 4'($urandom);
         carry_we = 1'($urandom);
         case (i % 4)
            0: reg_a = 32'h0;
            1: reg_a = 32'hFFFFFFFF;
            2: reg_a = 32'h80000000;
            default: reg_a = $urandom;
         endcase
         reg_b = (i % 3 == 0) ? 32'h80000000 : $urandom;
         imm = (i % 5 == 0) ? 32'hFFFFFFFF : $urandom;
         m = ref_model(a_sel, b_sel, cin_sel, fn_sel, carry_we, reg_a, reg_b, imm, mc);
         @(negedge clk);
         check("R2 R3 R7 random", result, carry, m[31:0], m[32]);
         mc = m[32];
      end

      // R11: stall with a pending carry write and new operands
      a_sel = 3'd0; b_sel = 2'd0; cin_sel = 2'd0; fn_sel = 4'd0; carry_we = 1'b1;
      reg_a = 32'hFFFFFFFF; reg_b = 32'h2;
      @(negedge clk);
      check("R4 pre-stall", result, carry, 32'h1, 1'b1);
      hr = result; hc = carry;
      stall = 1'b1; fn_sel = 4'd7; reg_a = 32'h10;
      repeat (3) begin
         @(negedge clk);
         check("R11 stall hold", result, carry, hr, hc);
      end
      stall = 1'b0; fn_sel = 4'd8; cin_sel = 2'd2; reg_a = 32'h10;
      @(negedge clk);
      check("R11 R8 after stall", result, carry, 32'h80000008, 1'b0);

      // R10: write enable set but function does not touch carry
      fn_sel = 4'd0; cin_sel = 2'd1; a_sel = 3'd0; reg_a = 32'hFFFFFFFF; reg_b = 32'h0;
      @(negedge clk);
      check("R10 set carry", result, carry, 32'h0, 1'b1);
      fn_sel = 4'd3; reg_a = 32'h3; reg_b = 32'h5;
      @(negedge clk);
      check("R10 xor keeps carry", result, carry, 32'h6, 1'b1);

      // R12: reset mid-run
      rst = 1'b1;
      @(negedge clk);
      check("R12 reset clears", result, carry, 32'h0, 1'b0);
      rst = 1'b0;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule